// File: doc/BRIEF.md
# Peer Registration Tracker

The tracker follows a stream of control messages from a coordinating server and keeps a record of which remote nodes are present and how many notification vectors each node has registered. Every message holds a signed position and a flag that tells whether a handle came with it. The tracker reads the position sign, the flag and the current vector count of the addressed peer. From these it decides whether the message gives the local node its own ID, reports that the shared memory is mapped, adds a vector to a peer, or removes a peer that has left.

Messages use a valid/ready handshake. Ready is always high, so the tracker takes one message in every cycle that valid is high, and each registered output reflects that message after the next rising clock edge. A combinational lookup port returns the vector count of any peer slot. Positions that do not fit the table set a sticky error flag and change nothing else.

Top module: `peer_reg_tracker`

## Requirements
- R1: After reset, own_id is all ones (-1, meaning unassigned), mem_mapped is 0, max_peer is 0, overflow_err is 0, and every peer's vector count is 0.
- R2: A message without a handle whose position is in the range 0 to PEER_DEPTH-1, addressed to a peer with a vector count of 0, makes own_id equal to that position after the clock edge. No vector count changes.
- R3: A message without a handle addressed to an in-range peer with a nonzero vector count clears that peer's count to 0. own_id does not change.
- R4: A message with a handle and position -1 (all ones) sets mem_mapped to 1 and sets max_peer to 0. mem_mapped stays 1 until reset.
- R5: A message with a handle and an in-range position adds one to that peer's vector count while the count is below VEC_MAX (default 4).
- R6: After a registration that is accepted, max_peer becomes the message position if the position is larger than the current max_peer. Otherwise max_peer keeps its value.
- R7: A registration for a peer whose count already equals VEC_MAX is dropped. Neither the count nor max_peer changes.
- R8: Two kinds of message set overflow_err: any message whose position is PEER_DEPTH (default 16) or larger, and any message with a negative position other than the handle-with--1 case. overflow_err stays set until reset, and such a message changes no other state.
- R9: msg_ready is always 1. In a cycle with msg_valid low, no state changes, whatever msg_pos and msg_has_handle hold.
- R10: lookup_count gives the vector count of slot lookup_id in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | Message accepted (always 1) |
| msg_pos | input | POS_W (16) | Signed position in two's complement |
| msg_has_handle | input | 1 | A handle came with the message |
| lookup_id | input | IDX_W (4) | Peer slot to read |
| lookup_count | output | CNT_W (3) | Vector count of slot lookup_id |
| own_id | output | POS_W (16) | Local node ID; all ones when unassigned |
| mem_mapped | output | 1 | Shared memory has been reported mapped |
| max_peer | output | IDX_W (4) | Highest peer ID registered |
| overflow_err | output | 1 | Sticky flag for a position that does not fit the table |

## Verification
A slot count that is wrong does more than show up at lookup_count, where it is visible at once. It also changes how the next message for that peer is classified. A message without a handle can then clear the count when it should set own_id, or the reverse, and this shows one clock edge later. A stale max_peer or mem_mapped value shows at its port on the edge right after the message that should have changed it. The directed scenarios are built so that every classification path is followed by a port check one cycle later.

// File: rtl/peer_reg_pkg.sv
package peer_reg_pkg;

    // Outcome of decoding one control message
    typedef enum logic [2:0] {
        KIND_NONE,   // no message this cycle
        KIND_MAP,    // handle with position -1: memory mapped
        KIND_SELF,   // no handle, unknown peer: own identity
        KIND_LEAVE,  // no handle, known peer: peer departed
        KIND_REG,    // handle, room left: add one vector
        KIND_FULL,   // handle, peer saturated: dropped
        KIND_BAD     // position outside the table
    } msg_kind_e;

endpackage

// File: rtl/peer_msg_classify.sv
module peer_msg_classify
    import peer_reg_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int PEER_DEPTH = 16,
    parameter int VEC_MAX    = 4,
    localparam int IDX_W     = $clog2(PEER_DEPTH),
    localparam int CNT_W     = $clog2(VEC_MAX + 1)
) (
    input  logic             msg_fire,
    input  logic [POS_W-1:0] msg_pos,
    input  logic             msg_has_handle,
    input  logic [CNT_W-1:0] peer_cnt,
    output logic [IDX_W-1:0] peer_idx,
    output msg_kind_e        kind
);

    localparam logic [POS_W-1:0] DEPTH_V = POS_W'(PEER_DEPTH);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(VEC_MAX);

    logic is_neg;
    logic is_neg_one;
    logic in_range;

    always_comb begin
        is_neg     = msg_pos[POS_W-1];
        is_neg_one = &msg_pos;
        in_range   = !is_neg && (msg_pos < DEPTH_V);
        peer_idx   = msg_pos[IDX_W-1:0];

        if (!msg_fire) begin
            kind = KIND_NONE;
        end else if (msg_has_handle && is_neg_one) begin
            kind = KIND_MAP;
        end else if (!in_range) begin
            kind = KIND_BAD;
        end else if (!msg_has_handle) begin
            kind = (peer_cnt == '0) ? KIND_SELF : KIND_LEAVE;
        end else begin
            kind = (peer_cnt < LIMIT_V) ? KIND_REG : KIND_FULL;
        end
    end

endmodule

// File: rtl/peer_vec_table.sv
module peer_vec_table #(
    parameter int PEER_DEPTH = 16,
    parameter int VEC_MAX    = 4,
    localparam int IDX_W     = $clog2(PEER_DEPTH),
    localparam int CNT_W     = $clog2(VEC_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_inc,
    input  logic             op_clr,
    input  logic [IDX_W-1:0] op_idx,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [CNT_W-1:0] rd_cnt_a,
    output logic [CNT_W-1:0] rd_cnt_b
);

    logic [CNT_W-1:0] slot_q [PEER_DEPTH];

    for (genvar g = 0; g < PEER_DEPTH; g++) begin : g_slot
        logic [CNT_W-1:0] cnt_d;
        logic             sel;

        always_comb begin
            sel   = (op_idx == IDX_W'(g));
            cnt_d = slot_q[g];
            if (sel && op_clr) begin
                cnt_d = '0;
            end else if (sel && op_inc) begin
                cnt_d = slot_q[g] + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= cnt_d;
            end
        end

        // A count moves only by one step up or by a clear
        assert_slot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_q[g] != $past(slot_q[g])) |->
            ((slot_q[g] == $past(slot_q[g]) + 1'b1) || (slot_q[g] == '0)));

        // Saturation: never beyond the configured vector limit
        assert_slot_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(slot_q[g]) <= VEC_MAX));
    end

    always_comb begin
        rd_cnt_a = (int'(rd_idx_a) < PEER_DEPTH) ? slot_q[rd_idx_a] : '0;
        rd_cnt_b = (int'(rd_idx_b) < PEER_DEPTH) ? slot_q[rd_idx_b] : '0;
    end

endmodule

// File: rtl/peer_reg_tracker.sv
module peer_reg_tracker
    import peer_reg_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int PEER_DEPTH = 16,
    parameter int VEC_MAX    = 4,
    localparam int IDX_W     = $clog2(PEER_DEPTH),
    localparam int CNT_W     = $clog2(VEC_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic [POS_W-1:0] msg_pos,
    input  logic             msg_has_handle,
    input  logic [IDX_W-1:0] lookup_id,
    output logic [CNT_W-1:0] lookup_count,
    output logic [POS_W-1:0] own_id,
    output logic             mem_mapped,
    output logic [IDX_W-1:0] max_peer,
    output logic             overflow_err
);

    typedef struct packed {
        logic [POS_W-1:0] own_id;
        logic             mapped;
        logic [IDX_W-1:0] max_peer;
        logic             overflow;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic             msg_fire;
    logic [IDX_W-1:0] peer_idx;
    logic [CNT_W-1:0] peer_cnt;
    msg_kind_e        kind;

    assign msg_ready = 1'b1;
    assign msg_fire  = msg_valid && msg_ready;

    peer_msg_classify #(
        .POS_W      (POS_W),
        .PEER_DEPTH (PEER_DEPTH),
        .VEC_MAX    (VEC_MAX)
    ) u_classify (
        .msg_fire       (msg_fire),
        .msg_pos        (msg_pos),
        .msg_has_handle (msg_has_handle),
        .peer_cnt       (peer_cnt),
        .peer_idx       (peer_idx),
        .kind           (kind)
    );

    peer_vec_table #(
        .PEER_DEPTH (PEER_DEPTH),
        .VEC_MAX    (VEC_MAX)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_inc   (kind == KIND_REG),
        .op_clr   (kind == KIND_LEAVE),
        .op_idx   (peer_idx),
        .rd_idx_a (peer_idx),
        .rd_idx_b (lookup_id),
        .rd_cnt_a (peer_cnt),
        .rd_cnt_b (lookup_count)
    );

    always_comb begin
        st_d = st_q;
        unique case (kind)
            KIND_MAP: begin
                st_d.mapped   = 1'b1;
                st_d.max_peer = '0;
            end
            KIND_SELF: begin
                st_d.own_id = msg_pos;
            end
            KIND_REG: begin
                if (peer_idx > st_q.max_peer) begin
                    st_d.max_peer = peer_idx;
                end
            end
            KIND_BAD: begin
                st_d.overflow = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.own_id   <= '1;
            st_q.mapped   <= 1'b0;
            st_q.max_peer <= '0;
            st_q.overflow <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign own_id       = st_q.own_id;
    assign mem_mapped   = st_q.mapped;
    assign max_peer     = st_q.max_peer;
    assign overflow_err = st_q.overflow;

    assert_mapped_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_mapped |=> mem_mapped);

    assert_map_clears_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_has_handle && (&msg_pos)) |=> (max_peer == '0) && mem_mapped);

    assert_own_id_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(own_id) |-> $past(msg_valid && !msg_has_handle));

    assert_max_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(max_peer) |-> (($past(max_peer) < max_peer) || (max_peer == '0)));

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> ($stable(own_id) && $stable(mem_mapped)
                        && $stable(max_peer) && $stable(overflow_err)));

endmodule

// File: tb/peer_reg_tracker_tb.sv
module peer_reg_tracker_tb;

    localparam int POS_W = 16;
    localparam int DEPTH = 16;
    localparam int VMAX  = 4;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(VMAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             msg_valid = 1'b0;
    logic             msg_ready;
    logic [POS_W-1:0] msg_pos = '0;
    logic             msg_has_handle = 1'b0;
    logic [IDX_W-1:0] lookup_id = '0;
    logic [CNT_W-1:0] lookup_count;
    logic [POS_W-1:0] own_id;
    logic             mem_mapped;
    logic [IDX_W-1:0] max_peer;
    logic             overflow_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    peer_reg_tracker #(
        .POS_W      (POS_W),
        .PEER_DEPTH (DEPTH),
        .VEC_MAX    (VMAX)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .msg_valid      (msg_valid),
        .msg_ready      (msg_ready),
        .msg_pos        (msg_pos),
        .msg_has_handle (msg_has_handle),
        .lookup_id      (lookup_id),
        .lookup_count   (lookup_count),
        .own_id         (own_id),
        .mem_mapped     (mem_mapped),
        .max_peer       (max_peer),
        .overflow_err   (overflow_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one message across one rising edge; returns on the next falling edge
    task automatic send(input int pos, input logic handle);
        msg_valid      = 1'b1;
        msg_pos        = POS_W'(pos);
        msg_has_handle = handle;
        @(negedge clk);
        msg_valid      = 1'b0;
        msg_pos        = '0;
        msg_has_handle = 1'b0;
    endtask

    task automatic count_of(input int idx, output logic [31:0] c);
        lookup_id = IDX_W'(idx);
        #1;
        c = 32'(lookup_count);
    endtask

    task automatic t_reset;
        logic [31:0] c;
        check("R1 own_id", 32'(own_id), 32'h0000FFFF);
        check("R1 mem_mapped", 32'(mem_mapped), 0);
        check("R1 max_peer", 32'(max_peer), 0);
        check("R1 overflow_err", 32'(overflow_err), 0);
        check("R9 msg_ready", 32'(msg_ready), 1);
        for (int i = 0; i < DEPTH; i++) begin
            count_of(i, c);
            check("R1 count zero", c, 0);
        end
    endtask

    task automatic t_idle;
        logic [31:0] c;
        msg_pos = 16'd5; msg_has_handle = 1'b1; msg_valid = 1'b0;
        @(negedge clk);
        msg_pos = 16'd6; msg_has_handle = 1'b0;
        @(negedge clk);
        msg_pos = '0; msg_has_handle = 1'b0;
        count_of(5, c);
        check("R9 idle no count", c, 0);
        check("R9 idle own_id", 32'(own_id), 32'h0000FFFF);
        check("R9 idle max_peer", 32'(max_peer), 0);
    endtask

    task automatic t_self;
        logic [31:0] c;
        send(3, 1'b0);
        check("R2 own_id set", 32'(own_id), 3);
        count_of(3, c);
        check("R2 count untouched", c, 0);
    endtask

    task automatic t_register_map;
        logic [31:0] c;
        send(7, 1'b1);
        count_of(7, c);
        check("R5 first vector", c, 1);
        check("R6 max raised", 32'(max_peer), 7);
        send(7, 1'b1);
        count_of(7, c);
        check("R5 second vector", c, 2);
        send(-1, 1'b1);
        check("R4 mapped", 32'(mem_mapped), 1);
        check("R4 max reset", 32'(max_peer), 0);
        count_of(7, c);
        check("R4 counts kept", c, 2);
        send(2, 1'b1);
        check("R6 max to 2", 32'(max_peer), 2);
        send(1, 1'b1);
        check("R6 max kept", 32'(max_peer), 2);
        lookup_id = IDX_W'(1);
        #1;
        check("R10 same-cycle lookup", 32'(lookup_count), 1);
        lookup_id = IDX_W'(2);
        #1;
        check("R10 lookup switch", 32'(lookup_count), 1);
        check("R4 still mapped", 32'(mem_mapped), 1);
    endtask

    task automatic t_saturate;
        logic [31:0] c;
        for (int k = 0; k < VMAX + 1; k++) send(9, 1'b1);
        count_of(9, c);
        check("R7 saturated", c, VMAX);
        check("R6 max 9", 32'(max_peer), 9);
        send(-1, 1'b1);
        check("R4 max cleared", 32'(max_peer), 0);
        send(9, 1'b1);
        count_of(9, c);
        check("R7 dropped count", c, VMAX);
        check("R7 dropped no max", 32'(max_peer), 0);
    endtask

    task automatic t_leave;
        logic [31:0] c;
        send(9, 1'b0);
        count_of(9, c);
        check("R3 cleared", c, 0);
        check("R3 own_id kept", 32'(own_id), 3);
        count_of(7, c);
        check("R3 other peer kept", c, 2);
        send(9, 1'b0);
        check("R2 own_id after leave", 32'(own_id), 9);
    endtask

    task automatic t_overflow;
        logic [31:0] c;
        check("R8 clear before", 32'(overflow_err), 0);
        send(16, 1'b1);
        check("R8 set at depth", 32'(overflow_err), 1);
        check("R8 max untouched", 32'(max_peer), 0);
        count_of(0, c);
        check("R8 alias slot untouched", c, 0);
        send(-1, 1'b0);
        check("R8 own_id untouched", 32'(own_id), 9);
        send(-5, 1'b1);
        check("R8 mapped kept", 32'(mem_mapped), 1);
        send(4, 1'b1);
        check("R8 sticky", 32'(overflow_err), 1);
        count_of(4, c);
        check("R5 after error", c, 1);
        check("R6 max 4", 32'(max_peer), 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_self();
        t_register_map();
        t_saturate();
        t_leave();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule